// File: doc/BRIEF.md
# Shared-DAC Audio Converter Sequencer

This block lets a single 16-bit audio DAC serve two purposes within every word period. At the start of a period it writes the current playback sample into the DAC and lets the output sample-and-hold pick it up. It then reuses the same DAC as the trial-value source of a successive-approximation conversion, which is resolved against an external comparator. The analog DAC, comparator and sample-and-hold switches sit outside. This block only sequences the byte loads, the deglitch and sample-and-hold controls and the 16-step search.

A falling edge on the active-low word-clock input starts each cycle. The DAC is fed through two byte-wide latches, and each latch has its own load strobe. With the default parameters, a full cycle takes 315 system clocks, which fits easily inside a 512-clock word period. When the cycle finishes, the converted word appears on `adc_word` together with a one-cycle `adc_done` pulse.

Top module: `dac_share_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `ld_hi`, `ld_lo`, `deglitch`, `out_track`, `in_hold` and `adc_done` all low, `dac_byte` at zero, and `adc_word` cleared to zero.
- R2: A cycle starts only on the edge where `wc_n` is sampled low after having been sampled high. With `wc_n` held high, no strobe, control or done pulse appears. Holding `wc_n` low for many cycles starts exactly one cycle.
- R3: `play_sample` is captured on the start edge. In the first cycle after that edge, `ld_hi` is high and `dac_byte` carries bits 15:8 of the sample. In the second cycle, `ld_lo` is high and `dac_byte` carries bits 7:0. From then until tracking, the DAC holds the playback sample.
- R4: `deglitch` is high from the first playback load through `DG_CYC` (default 8) cycles after the low-byte load, which makes 10 cycles in total. After that, `out_track` is high for exactly `TRK_CYC` (default 16) cycles, and `deglitch` is low during tracking.
- R5: `in_hold` goes high in the cycle after tracking ends. It stays high through all 16 conversion steps and is low in the done cycle and at all other times.
- R6: The conversion resolves bits from bit 15 down to bit 0. Each step loads the trial value, which is the bits already decided with the current bit set. The high byte is loaded with `ld_hi` and the low byte with `ld_lo` on consecutive cycles, so the first trial is 0x8000.
- R7: The comparator input `comp_above` is sampled `SETTLE_CYC` (default 16) cycles after the low-byte trial load. A value of 1 means the DAC is above the input, and that clears the current bit; a value of 0 keeps it. With an ideal comparator, the result equals the analog input code.
- R8: `adc_done` is high for exactly one cycle, 315 cycles after the start edge with the default parameters. In that cycle `adc_word` shows the new result, and `adc_word` then holds that value until the next completed conversion.
- R9: A new start edge during an active cycle abandons that cycle and restarts the sequence from the playback load. The abandoned cycle gives no `adc_done`, and `adc_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wc_n | input | 1 | Active-low word-clock strobe; its falling edge starts a cycle |
| play_sample | input | 16 | Playback sample to send to the DAC |
| comp_above | input | 1 | Comparator result: 1 when the DAC output is above the analog input |
| dac_byte | output | 8 | Byte bus to the two DAC latches |
| ld_hi | output | 1 | Load strobe for the DAC high-byte latch |
| ld_lo | output | 1 | Load strobe for the DAC low-byte latch |
| deglitch | output | 1 | Blanks the DAC output while it settles after a playback load |
| out_track | output | 1 | Output sample-and-hold tracks the DAC while high |
| in_hold | output | 1 | Input sample-and-hold holds the analog input while high |
| adc_word | output | 16 | Most recent conversion result |
| adc_done | output | 1 | One-cycle pulse when a conversion result is presented |

## Verification
The bench models the DAC latches and an ideal comparator. It drives analog codes at both extremes, at the midpoint and on either side of it, single-bit-from-the-end values and mixed patterns. These show whether every bit decision follows the comparator and whether a bit is set or cleared by mistake. Pairing each code with a different playback sample shows whether the playback and conversion halves stay separate on the shared byte bus. A restart in mid-conversion, a word clock held low, a long idle stretch and a reset in mid-cycle show whether restart priority, edge detection and result retention behave as required.

// File: rtl/dss_pkg.sv
// Shared types for the shared-DAC converter sequencer.
// Assumes: one sequencer instance per DAC; states are one-per-phase.
package dss_pkg;

    // Phase of the word-period sequence.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PB_HI,
        ST_PB_LO,
        ST_PB_SETTLE,
        ST_TRACK,
        ST_SAR_HI,
        ST_SAR_LO,
        ST_SAR_WAIT,
        ST_DONE
    } seq_state_t;

    // Largest of three cycle counts, used to size the shared wait counter.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dss_wc_detect.sv
// Word-clock start detector.
// Produces a one-cycle start strobe on the first cycle the active-low word
// clock is seen low after being high. Assumes wc_n is already synchronous
// to clk.
module dss_wc_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic wc_n,
    output logic start
);

    logic wc_d;

    // Remember the previous word-clock level; reset treats it as idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) wc_d <= 1'b1;
        else        wc_d <= wc_n;
    end

    // A high-to-low transition marks the start of a word period.
    assign start = wc_d & ~wc_n;

    // A held-low word clock yields no second strobe (R2).
    assert_single_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

// File: rtl/dss_seq_ctrl.sv
// Sequencer for one word period of the shared DAC.
// Order: playback high/low byte load, deglitch settle, output track window,
// then DATA_W successive-approximation steps (trial load high, low, settle,
// compare), then a one-cycle done. A start strobe at any point restarts.
// Assumes all cycle-count parameters are at least 1.
module dss_seq_ctrl
    import dss_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned DG_CYC     = 8,
    parameter int unsigned TRK_CYC    = 16,
    parameter int unsigned SETTLE_CYC = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    output logic [$clog2(DATA_W)-1:0]   bit_idx,
    output logic                        step_sample,
    output logic                        step_last,
    output logic                        ld_hi,
    output logic                        ld_lo,
    output logic                        use_trial,
    output logic                        deglitch,
    output logic                        out_track,
    output logic                        in_hold,
    output logic                        done
);

    localparam int unsigned BIT_W   = $clog2(DATA_W);
    localparam int unsigned CNT_MAX = max3(DG_CYC, TRK_CYC, SETTLE_CYC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [BIT_W-1:0] TOP_BIT     = BIT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] DG_LAST     = CNT_W'(DG_CYC - 1);
    localparam logic [CNT_W-1:0] TRK_LAST    = CNT_W'(TRK_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    seq_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [BIT_W-1:0]   bit_q, bit_d;

    // Next-state logic: start has priority over every phase.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        if (start) begin
            state_d = ST_PB_HI;
            cnt_d   = '0;
            bit_d   = TOP_BIT;
        end else begin
            case (state_q)
                ST_IDLE: ;
                ST_PB_HI: state_d = ST_PB_LO;
                ST_PB_LO: begin
                    state_d = ST_PB_SETTLE;
                    cnt_d   = '0;
                end
                ST_PB_SETTLE: begin
                    if (cnt_q == DG_LAST) begin
                        state_d = ST_TRACK;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_TRACK: begin
                    if (cnt_q == TRK_LAST) begin
                        state_d = ST_SAR_HI;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SAR_HI: state_d = ST_SAR_LO;
                ST_SAR_LO: begin
                    state_d = ST_SAR_WAIT;
                    cnt_d   = '0;
                end
                ST_SAR_WAIT: begin
                    if (cnt_q == SETTLE_LAST) begin
                        cnt_d = '0;
                        if (bit_q == '0) begin
                            state_d = ST_DONE;
                        end else begin
                            state_d = ST_SAR_HI;
                            bit_d   = bit_q - 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DONE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State, wait counter and bit index registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
        end
    end

    // Moore decode of the strobes and analog controls from the phase.
    always_comb begin
        ld_hi     = (state_q == ST_PB_HI) || (state_q == ST_SAR_HI);
        ld_lo     = (state_q == ST_PB_LO) || (state_q == ST_SAR_LO);
        use_trial = (state_q == ST_SAR_HI) || (state_q == ST_SAR_LO);
        deglitch  = (state_q == ST_PB_HI) || (state_q == ST_PB_LO) ||
                    (state_q == ST_PB_SETTLE);
        out_track = (state_q == ST_TRACK);
        in_hold   = (state_q == ST_SAR_HI) || (state_q == ST_SAR_LO) ||
                    (state_q == ST_SAR_WAIT);
        done      = (state_q == ST_DONE);
    end

    // Comparator is taken on the last settle cycle unless a restart wins.
    assign step_sample = (state_q == ST_SAR_WAIT) && (cnt_q == SETTLE_LAST) && !start;
    assign step_last   = (bit_q == '0);
    assign bit_idx     = bit_q;

    // High-byte load is always followed by the matching low-byte load (R6).
    assert_hi_then_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !start) |=> ld_lo);

    // Done is a single-cycle pulse (R8).
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Tracking only begins straight after the deglitch window (R4).
    assert_track_after_deglitch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_track) |-> $past(deglitch));

    // Comparator is only taken while the input is held (R7).
    assert_sample_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_sample |-> in_hold);

    // Without a start edge the idle sequencer stays idle (R2).
    assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dss_sar_reg.sv
// Successive-approximation register.
// Holds the bits decided so far, forms the trial value with the current bit
// set, and on each compare keeps or drops that bit. The final compare loads
// the result register, which otherwise holds. Assumes bit_idx steps down.
module dss_sar_reg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        sample,
    input  logic                        last,
    input  logic [$clog2(DATA_W)-1:0]   bit_idx,
    input  logic                        comp_above,
    output logic [DATA_W-1:0]           trial,
    output logic [DATA_W-1:0]           result
);

    logic [DATA_W-1:0] sar_q;
    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] decided;

    // Mask of the bit under test and of the bits still undecided below it.
    assign bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
    assign low_mask = bit_mask - 1'b1;
    assign trial    = sar_q | bit_mask;

    // Comparator above input drops the trial bit, otherwise it is kept.
    assign decided  = comp_above ? sar_q : trial;

    // Decided bits: cleared on a new cycle, updated on each compare.
    always_ff @(posedge clk) begin
        if (!rst_n)       sar_q <= '0;
        else if (clear)   sar_q <= '0;
        else if (sample)  sar_q <= decided;
    end

    // Published result: loaded only by the final compare.
    always_ff @(posedge clk) begin
        if (!rst_n)                 result <= '0;
        else if (sample && last)    result <= decided;
    end

    // Bits below the one under test are still undecided, i.e. zero (R6).
    assert_low_bits_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> ((sar_q & low_mask) == '0));

endmodule

// File: rtl/dss_dac_port.sv
// DAC byte port.
// Captures the playback sample at the start of a cycle and drives the byte
// bus from either that sample or the current trial value, high byte with the
// high strobe and low byte with the low strobe; zero when no strobe is active.
module dss_dac_port #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [2*BYTE_W-1:0]   play_sample,
    input  logic [2*BYTE_W-1:0]   trial,
    input  logic                  use_trial,
    input  logic                  sel_hi,
    input  logic                  sel_lo,
    output logic [BYTE_W-1:0]     dac_byte
);

    localparam int unsigned DATA_W = 2 * BYTE_W;

    logic [DATA_W-1:0] play_q;
    logic [DATA_W-1:0] src;

    // Playback sample register, loaded on the word-clock start.
    always_ff @(posedge clk) begin
        if (!rst_n)       play_q <= '0;
        else if (capture) play_q <= play_sample;
    end

    // Pick the word to send: trial during conversion, playback otherwise.
    assign src = use_trial ? trial : play_q;

    // Byte-lane select for the two DAC latches.
    always_comb begin
        if (sel_hi)      dac_byte = src[DATA_W-1:BYTE_W];
        else if (sel_lo) dac_byte = src[BYTE_W-1:0];
        else             dac_byte = '0;
    end

    // The two latch strobes never coincide (R3).
    assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_hi && sel_lo));

endmodule

// File: rtl/dac_share_seq.sv
// Shared-DAC audio converter sequencer, top level.
// Each word period: play back one sample through the DAC, then use the DAC
// as the trial source for a successive-approximation conversion against an
// external comparator. Assumes wc_n and comp_above are synchronous to clk.
module dac_share_seq #(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned DG_CYC     = 8,
    parameter int unsigned TRK_CYC    = 16,
    parameter int unsigned SETTLE_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wc_n,
    input  logic [2*BYTE_W-1:0]   play_sample,
    input  logic                  comp_above,
    output logic [BYTE_W-1:0]     dac_byte,
    output logic                  ld_hi,
    output logic                  ld_lo,
    output logic                  deglitch,
    output logic                  out_track,
    output logic                  in_hold,
    output logic [2*BYTE_W-1:0]   adc_word,
    output logic                  adc_done
);

    localparam int unsigned DATA_W = 2 * BYTE_W;
    localparam int unsigned BIT_W  = $clog2(DATA_W);

    logic              start;
    logic [BIT_W-1:0]  bit_idx;
    logic              step_sample;
    logic              step_last;
    logic              use_trial;
    logic [DATA_W-1:0] trial;

    dss_wc_detect u_wc (
        .clk   (clk),
        .rst_n (rst_n),
        .wc_n  (wc_n),
        .start (start)
    );

    dss_seq_ctrl #(
        .DATA_W     (DATA_W),
        .DG_CYC     (DG_CYC),
        .TRK_CYC    (TRK_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .bit_idx     (bit_idx),
        .step_sample (step_sample),
        .step_last   (step_last),
        .ld_hi       (ld_hi),
        .ld_lo       (ld_lo),
        .use_trial   (use_trial),
        .deglitch    (deglitch),
        .out_track   (out_track),
        .in_hold     (in_hold),
        .done        (adc_done)
    );

    dss_sar_reg #(
        .DATA_W (DATA_W)
    ) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .sample     (step_sample),
        .last       (step_last),
        .bit_idx    (bit_idx),
        .comp_above (comp_above),
        .trial      (trial),
        .result     (adc_word)
    );

    dss_dac_port #(
        .BYTE_W (BYTE_W)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (start),
        .play_sample (play_sample),
        .trial       (trial),
        .use_trial   (use_trial),
        .sel_hi      (ld_hi),
        .sel_lo      (ld_lo),
        .dac_byte    (dac_byte)
    );

    // The result stays put after it is presented (R8).
    assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_done |=> $stable(adc_word));

    // Done directly follows the held conversion phase (R5).
    assert_done_after_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_done) |-> $past(in_hold));

    // Output tracking and input hold never overlap (R5).
    assert_track_hold_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_track && in_hold));

endmodule

// File: tb/tb_dac_share_seq.sv
// Self-checking bench: vector table of playback/analog codes walked by one
// loop, then directed tests for reset, idle, restart and held word clock.
module tb_dac_share_seq;

    localparam int DG      = 8;
    localparam int TRK     = 16;
    localparam int SET     = 16;
    localparam int T_TRACK = 2 + DG;
    localparam int T_SAR   = T_TRACK + TRK;
    localparam int STEP    = 2 + SET;
    localparam int T_DONE  = T_SAR + 16 * STEP;
    localparam int NVEC    = 8;
    // {playback sample, analog input code}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h1111_0000, 32'hEEEE_FFFF, 32'h0F0F_8000, 32'hF0F0_7FFF,
        32'hCAFE_1234, 32'h5A5A_A5A5, 32'h8001_0001, 32'h7FFE_FFFE
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wc_n = 1'b1;
    logic [15:0] play_sample = '0;
    logic        comp_above;
    logic [7:0]  dac_byte;
    logic        ld_hi, ld_lo, deglitch, out_track, in_hold, adc_done;
    logic [15:0] adc_word;

    logic [15:0] ain = '0;
    logic [7:0]  m_hi = '0;
    logic [7:0]  m_lo = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    dac_share_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wc_n        (wc_n),
        .play_sample (play_sample),
        .comp_above  (comp_above),
        .dac_byte    (dac_byte),
        .ld_hi       (ld_hi),
        .ld_lo       (ld_lo),
        .deglitch    (deglitch),
        .out_track   (out_track),
        .in_hold     (in_hold),
        .adc_word    (adc_word),
        .adc_done    (adc_done)
    );

    // DAC latch model and ideal comparator.
    always @(posedge clk) begin
        if (ld_hi) m_hi <= dac_byte;
        if (ld_lo) m_lo <= dac_byte;
    end
    assign comp_above = ({m_hi, m_lo} > ain);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Start a cycle at the current negedge and observe up to n_last.
    task automatic run_seq(input logic [15:0] play, input logic [15:0] a,
                           input int n_last, input bit full, output int dones);
        int e_dg = 0, e_tr = 0, e_ho = 0, e_ld = 0;
        int done_at = -1;
        logic [15:0] dac_at_track = '0;
        logic [7:0] b0 = '0, b1 = '0, t0 = '0, t1 = '0;
        dones = 0;
        play_sample = play;
        ain = a;
        wc_n = 1'b0;
        for (int n = 0; n <= n_last; n++) begin
            bit x_hi, x_lo;
            @(negedge clk);
            if (n == 0) wc_n = 1'b1;
            x_hi = (n == 0) || (n >= T_SAR && n < T_DONE && (n - T_SAR) % STEP == 0);
            x_lo = (n == 1) || (n > T_SAR && n < T_DONE && (n - T_SAR - 1) % STEP == 0);
            if (deglitch  != (n < T_TRACK)) e_dg++;
            if (out_track != (n >= T_TRACK && n < T_SAR)) e_tr++;
            if (in_hold   != (n >= T_SAR && n < T_DONE)) e_ho++;
            if (ld_hi != x_hi || ld_lo != x_lo) e_ld++;
            if (adc_done) begin
                dones++;
                if (done_at < 0) done_at = n;
            end
            if (n == 0) b0 = dac_byte;
            if (n == 1) b1 = dac_byte;
            if (n == T_TRACK) dac_at_track = {m_hi, m_lo};
            if (n == T_SAR) t0 = dac_byte;
            if (n == T_SAR + 1) t1 = dac_byte;
        end
        if (full) begin
            chk(b0 == play[15:8], "R3 playback high byte", 32'(b0), 32'(play[15:8]));
            chk(b1 == play[7:0], "R3 playback low byte", 32'(b1), 32'(play[7:0]));
            chk(dac_at_track == play, "R3 DAC holds playback at track", 32'(dac_at_track), 32'(play));
            chk(e_dg == 0, "R4 deglitch window", 32'(e_dg), 0);
            chk(e_tr == 0, "R4 track window", 32'(e_tr), 0);
            chk(e_ho == 0, "R5 input hold window", 32'(e_ho), 0);
            chk(e_ld == 0, "R6 load strobe pattern", 32'(e_ld), 0);
            chk({t0, t1} == 16'h8000, "R6 first trial", 32'({t0, t1}), 32'h8000);
            chk(adc_word == a, "R7 conversion result", 32'(adc_word), 32'(a));
            chk(dones == 1 && done_at == T_DONE, "R8 done timing", 32'(done_at), 32'(T_DONE));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int dn;
        int act;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({ld_hi, ld_lo, deglitch, out_track, in_hold, adc_done} == '0,
            "R1 controls low in reset", 32'({ld_hi, ld_lo, deglitch, out_track, in_hold, adc_done}), 0);
        chk(adc_word == '0 && dac_byte == '0, "R1 result and bus zero", 32'(adc_word), 0);
        rst_n = 1'b1;

        // R2: no activity without a word-clock edge
        act = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (ld_hi || ld_lo || deglitch || out_track || in_hold || adc_done) act++;
        end
        chk(act == 0, "R2 idle without word clock", 32'(act), 0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            run_seq(VEC[v][31:16], VEC[v][15:0], T_DONE + 6, 1'b1, dn);
            chk(adc_word == VEC[v][15:0], "R8 result held after done", 32'(adc_word), 32'(VEC[v][15:0]));
        end

        // R9: restart in mid-conversion
        run_seq(16'h3333, 16'h4444, 100, 1'b0, dn);
        chk(dn == 0, "R9 no done for abandoned cycle", 32'(dn), 0);
        chk(adc_word == VEC[NVEC-1][15:0], "R9 previous result kept", 32'(adc_word), 32'(VEC[NVEC-1][15:0]));
        run_seq(16'h9876, 16'h0C3A, T_DONE + 2, 1'b1, dn);

        // R2: held-low word clock starts exactly one cycle
        wc_n = 1'b0;
        ain = 16'h2468;
        dn = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (adc_done) dn++;
        end
        wc_n = 1'b1;
        chk(dn == 1, "R2 held-low word clock single cycle", 32'(dn), 1);
        chk(adc_word == 16'h2468, "R2 held-low result", 32'(adc_word), 32'h2468);

        // R1: reset in mid-cycle
        run_seq(16'hABCD, 16'h1357, 150, 1'b0, dn);
        rst_n = 1'b0;
        @(negedge clk);
        chk({ld_hi, ld_lo, deglitch, out_track, in_hold, adc_done} == '0,
            "R1 controls low after mid-cycle reset",
            32'({ld_hi, ld_lo, deglitch, out_track, in_hold, adc_done}), 0);
        chk(adc_word == '0, "R1 result cleared by reset", 32'(adc_word), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_seq(16'h0102, 16'hBEEF, T_DONE + 2, 1'b1, dn);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule